// File: doc/BRIEF.md
# Posted-Write Burst Memory Buffer

This block wraps a small synchronous storage array with one write port and one read port that run independently. A write request carries a burst address, four beats of data presented side by side on one wide bus, and one byte-enable bit per byte of every beat. The write is not stored in the array straight away. It is parked in a two-entry queue of pending writes and drains into the array only when a later accepted write pushes it out of the queue.

Reads look up the array and both pending entries in parallel. For each byte, the newest matching pending write with that byte enabled wins. Failing that, the older matching entry supplies the byte, and otherwise the array does. A read therefore always reflects every write accepted before it, whether or not that write has reached the array. A static mode pin picks the read latency: two cycles normally, or one cycle in the legacy setting.

Top module: `wbufTop`

## Requirements
- R1: An accepted write is stored into the array on the clock edge that accepts the second accepted write after it. Reads stay coherent before, during and after that store.
- R2: A read whose burst address matches the newest pending write returns that write's enabled bytes.
- R3: Each byte of read data comes from the newest pending entry that matches the address and has that byte enabled. If there is none, it comes from the older matching entry with the byte enabled, and otherwise from the array.
- R4: When `wrEnN` is sampled high at a rising edge, the data, address and mask inputs have no effect on any later read.
- R5: A read and a write may be issued in the same cycle. The read returns the contents as they stood before that write.
- R6: With `legacyMode` low, a read sampled at edge k drives `rdValid` high and the data on `rdData` after edge k+1, for one cycle. `rdValid` is never high without a matching request.
- R7: With `legacyMode` high, a read sampled at edge k drives `rdValid` high and the data after edge k itself.
- R8: While `rstN` is low, the array is cleared to zero, the queue is emptied and `rdValid` is low.
- R9: Pending writes stay in the queue across any number of idle cycles and remain visible to reads.
- R10: Mask bit l enables data byte l, which is `wrData[8*l+7:8*l]`. Beat b occupies bytes b*BEAT_BYTES through b*BEAT_BYTES+BEAT_BYTES-1, and beat 0 is the lowest. `rdData` uses the same layout, and a mask bit of 1 means the byte is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Synchronous reset, active low |
| legacyMode | input | 1 | Static latency select: 1 gives one-cycle reads |
| wrEnN | input | 1 | Write request, active low |
| wrAddr | input | ADDR_W | Burst address of the write |
| wrData | input | BEATS*BEAT_BYTES*8 | Four beats of write data |
| wrMask | input | BEATS*BEAT_BYTES | Byte enables, 1 = write the byte |
| rdEnN | input | 1 | Read request, active low |
| rdAddr | input | ADDR_W | Burst address of the read |
| rdData | output | BEATS*BEAT_BYTES*8 | Four beats of read data |
| rdValid | output | 1 | Read data is valid this cycle |

## Verification
Corrupted queue state cannot stay hidden here. A lost or misordered pending entry, a wrong hit comparison or a bad byte select all show up as wrong bytes on `rdData` for the first read to the affected address. That read can come as early as the cycle after the write. A premature or missing commit surfaces two writes later, once the entry has left the queue and the array alone is supplying the data. A latency fault shows up at once as `rdValid` out of position with respect to the request.

// File: rtl/wbufPkg.sv
package wbufPkg;

  // Strobes the control half hands to the datapath each cycle.
  typedef struct packed {
    logic push;       // shift queue: new write enters newest slot
    logic commit;     // oldest slot drains into the array this edge
    logic newValid;   // newest slot holds a pending write
    logic oldValid;   // oldest slot holds a pending write
    logic rdLoad;     // first read stage captures merged data
    logic rdAdvance;  // second read stage captures first stage
    logic outSecond;  // drive port from second stage (normal latency)
  } wbStrobe_t;

endpackage

// File: rtl/wbufCtrl.sv
module wbufCtrl
  import wbufPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      wrEnN,
  input  logic      rdEnN,
  input  logic      legacyMode,
  output wbStrobe_t strobe,
  output logic      rdValid
);

  logic newValidQ;
  logic oldValidQ;
  logic stage1Q;
  logic stage2Q;
  logic accept;

  assign accept = ~wrEnN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      newValidQ <= 1'b0;
      oldValidQ <= 1'b0;
      stage1Q   <= 1'b0;
      stage2Q   <= 1'b0;
    end else begin
      if (accept) begin
        oldValidQ <= newValidQ;
        newValidQ <= 1'b1;
      end
      stage1Q <= ~rdEnN;
      stage2Q <= stage1Q & ~legacyMode;
    end
  end

  always_comb begin
    strobe.push      = accept;
    strobe.commit    = accept & oldValidQ;
    strobe.newValid  = newValidQ;
    strobe.oldValid  = oldValidQ;
    strobe.rdLoad    = ~rdEnN;
    strobe.rdAdvance = stage1Q;
    strobe.outSecond = ~legacyMode;
  end

  assign rdValid = legacyMode ? stage1Q : stage2Q;

endmodule

// File: rtl/wbufDatapath.sv
module wbufDatapath
  import wbufPkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int BEAT_BYTES = 2,
  parameter int BEATS      = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  wbStrobe_t                     strobe,
  input  logic [ADDR_W-1:0]             wrAddr,
  input  logic [BEATS*BEAT_BYTES*8-1:0] wrData,
  input  logic [BEATS*BEAT_BYTES-1:0]   wrMask,
  input  logic [ADDR_W-1:0]             rdAddr,
  output logic [BEATS*BEAT_BYTES*8-1:0] rdData
);

  localparam int LANES = BEATS * BEAT_BYTES;
  localparam int DW    = LANES * 8;
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0]        mem [DEPTH][LANES];

  logic [ADDR_W-1:0] newAddr, oldAddr;
  logic [DW-1:0]     newData, oldData;
  logic [LANES-1:0]  newMask, oldMask;

  logic              newHit, oldHit;
  logic [DW-1:0]     merged;
  logic [DW-1:0]     stage1Data, stage2Data;

  // Two-deep pending queue; shifts only on an accepted write.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      newAddr <= '0;
      oldAddr <= '0;
      newData <= '0;
      oldData <= '0;
      newMask <= '0;
      oldMask <= '0;
    end else if (strobe.push) begin
      oldAddr <= newAddr;
      oldData <= newData;
      oldMask <= newMask;
      newAddr <= wrAddr;
      newData <= wrData;
      newMask <= wrMask;
    end
  end

  // Storage array, byte-wise commit of the entry leaving the queue.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int a = 0; a < DEPTH; a++) begin
        for (int l = 0; l < LANES; l++) begin
          mem[a][l] <= 8'h00;
        end
      end
    end else if (strobe.commit) begin
      for (int l = 0; l < LANES; l++) begin
        if (oldMask[l]) begin
          mem[oldAddr][l] <= oldData[l*8 +: 8];
        end
      end
    end
  end

  assign newHit = strobe.newValid && (newAddr == rdAddr);
  assign oldHit = strobe.oldValid && (oldAddr == rdAddr);

  // Per-byte forwarding: newest entry, then older entry, then array.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] laneOut;
    assign laneOut = (newHit && newMask[l]) ? newData[l*8 +: 8] :
                     (oldHit && oldMask[l]) ? oldData[l*8 +: 8] :
                                              mem[rdAddr][l];
    assign merged[l*8 +: 8] = laneOut;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage1Data <= '0;
      stage2Data <= '0;
    end else begin
      if (strobe.rdLoad)    stage1Data <= merged;
      if (strobe.rdAdvance) stage2Data <= stage1Data;
    end
  end

  assign rdData = strobe.outSecond ? stage2Data : stage1Data;

endmodule

// File: rtl/wbufTop.sv
module wbufTop
  import wbufPkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int BEAT_BYTES = 2,
  parameter int BEATS      = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          legacyMode,
  input  logic                          wrEnN,
  input  logic [ADDR_W-1:0]             wrAddr,
  input  logic [BEATS*BEAT_BYTES*8-1:0] wrData,
  input  logic [BEATS*BEAT_BYTES-1:0]   wrMask,
  input  logic                          rdEnN,
  input  logic [ADDR_W-1:0]             rdAddr,
  output logic [BEATS*BEAT_BYTES*8-1:0] rdData,
  output logic                          rdValid
);

  wbStrobe_t strobe;

  wbufCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEnN      (wrEnN),
    .rdEnN      (rdEnN),
    .legacyMode (legacyMode),
    .strobe     (strobe),
    .rdValid    (rdValid)
  );

  wbufDatapath #(
    .ADDR_W     (ADDR_W),
    .BEAT_BYTES (BEAT_BYTES),
    .BEATS      (BEATS)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .wrMask (wrMask),
    .rdAddr (rdAddr),
    .rdData (rdData)
  );

endmodule

// File: rtl/wbufChecker.sv
module wbufChecker
  import wbufPkg::*;
(
  input logic      clk,
  input logic      rstN,
  input logic      legacyMode,
  input logic      wrEnN,
  input logic      rdEnN,
  input logic      rdValid,
  input wbStrobe_t strobe
);

  // R4: a disabled write leaves the queue occupancy untouched
  assert_disabled_write_inert_R4: assert property (@(posedge clk) disable iff (!rstN)
    wrEnN |=> ($stable(strobe.newValid) && $stable(strobe.oldValid)));

  // R1: a commit happens only when two writes are already pending
  assert_commit_on_third_R1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |-> (strobe.oldValid && strobe.newValid && !wrEnN));

  // R1: the older slot is never occupied without the newer one
  assert_queue_order_R1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.oldValid |-> strobe.newValid);

  // R7: legacy reads complete one cycle after the request
  assert_legacy_latency_R7: assert property (@(posedge clk) disable iff (!rstN)
    (legacyMode && !rdEnN) |=> rdValid);

  // R6: normal reads complete two cycles after the request
  assert_normal_latency_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!legacyMode && !rdEnN) |=> ##1 rdValid);

  // R6: no valid without a request one cycle earlier in legacy mode
  assert_no_spurious_legacy_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && legacyMode && $past(rstN)) |-> $past(!rdEnN));

endmodule

bind wbufTop wbufChecker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .legacyMode (legacyMode),
  .wrEnN      (wrEnN),
  .rdEnN      (rdEnN),
  .rdValid    (rdValid),
  .strobe     (strobe)
);

// File: tb/sim_wbufTop.sv
module sim_wbufTop;

  localparam int ADDR_W     = 4;
  localparam int BEAT_BYTES = 2;
  localparam int BEATS      = 4;
  localparam int LANES      = BEATS * BEAT_BYTES;
  localparam int DW         = LANES * 8;
  localparam int DEPTH      = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rstN;
  logic              legacyMode;
  logic              wrEnN;
  logic [ADDR_W-1:0] wrAddr;
  logic [DW-1:0]     wrData;
  logic [LANES-1:0]  wrMask;
  logic              rdEnN;
  logic [ADDR_W-1:0] rdAddr;
  logic [DW-1:0]     rdData;
  logic              rdValid;

  always #5 clk = ~clk;

  wbufTop #(.ADDR_W(ADDR_W), .BEAT_BYTES(BEAT_BYTES), .BEATS(BEATS)) u0 (
    .clk(clk), .rstN(rstN), .legacyMode(legacyMode),
    .wrEnN(wrEnN), .wrAddr(wrAddr), .wrData(wrData), .wrMask(wrMask),
    .rdEnN(rdEnN), .rdAddr(rdAddr), .rdData(rdData), .rdValid(rdValid)
  );

  int            checks   = 0;
  int            failures = 0;
  int            edgeCnt  = 0;
  logic [DW-1:0] refMem [DEPTH];
  logic [DW-1:0] slotData [4];
  logic          slotValid [4];
  string         slotTag [4];
  logic [31:0]   seed = 32'h1234_5678;

  function automatic logic [31:0] nextRand(logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  task automatic checkVal(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One clock of stimulus; the reference memory is updated at once.
  task automatic step(string tag, logic wenN, logic [ADDR_W-1:0] wa, logic [DW-1:0] wd,
                      logic [LANES-1:0] wm, logic renN, logic [ADDR_W-1:0] ra);
    int slot;
    wrEnN  = wenN;
    wrAddr = wa;
    wrData = wd;
    wrMask = wm;
    rdEnN  = renN;
    rdAddr = ra;
    if (!renN) begin
      slot = (edgeCnt + 1 + (legacyMode ? 0 : 1)) % 4;
      slotValid[slot] = 1'b1;
      slotData[slot]  = refMem[ra];
      slotTag[slot]   = tag;
    end
    if (!wenN) begin
      for (int l = 0; l < LANES; l++) begin
        if (wm[l]) refMem[wa][l*8 +: 8] = wd[l*8 +: 8];
      end
    end
    @(posedge clk);
    edgeCnt++;
    @(negedge clk);
    slot = edgeCnt % 4;
    checkVal(slotValid[slot] ? {slotTag[slot], " valid"} : "R6 no spurious valid",
             {{(DW-1){1'b0}}, rdValid}, {{(DW-1){1'b0}}, slotValid[slot]});
    if (slotValid[slot] && rdValid) checkVal(slotTag[slot], rdData, slotData[slot]);
    slotValid[slot] = 1'b0;
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) step(tag, 1'b1, '0, '0, '0, 1'b1, '0);
  endtask

  task automatic doReset(logic mode);
    rstN = 1'b0;
    legacyMode = mode;
    wrEnN = 1'b1; rdEnN = 1'b1;
    wrAddr = '0; rdAddr = '0; wrData = '0; wrMask = '0;
    for (int a = 0; a < DEPTH; a++) refMem[a] = '0;
    for (int s = 0; s < 4; s++) slotValid[s] = 1'b0;
    repeat (3) @(negedge clk);
    checkVal("R8 rdValid low in reset", {{(DW-1){1'b0}}, rdValid}, '0);
    rstN = 1'b1;
  endtask

  function automatic logic [DW-1:0] pat(int a, int k);
    logic [DW-1:0] v;
    for (int l = 0; l < LANES; l++) v[l*8 +: 8] = 8'((a * 16) + l + (k * 37) + 1);
    return v;
  endfunction

  task automatic runMode(logic mode);
    logic [31:0] r1, r2;
    doReset(mode);
    // R8: array reads back zero after reset
    for (int a = 0; a < DEPTH; a++) step("R8 cleared array", 1'b1, '0, '0, '0, 1'b0, ADDR_W'(a));
    idle("R6 drain", 3);
    // R2 / R5 / R10: write full bursts, same-cycle read sees old, next read sees new
    for (int a = 0; a < DEPTH; a++) begin
      step("R5 same-cycle read", 1'b0, ADDR_W'(a), pat(a, 1), '1, 1'b0, ADDR_W'(a));
      step("R2 newest forward", 1'b1, '0, '0, '0, 1'b0, ADDR_W'(a));
    end
    // R1: the entry two writes back is read after it has reached the array
    for (int a = 0; a < DEPTH; a++) step("R1 older forward", 1'b1, '0, '0, '0, 1'b0, ADDR_W'(a));
    // R3 / R10: overlapping partial masks on one address
    for (int a = 0; a < DEPTH; a++) begin
      step("R10 lane mask", 1'b0, ADDR_W'(a), pat(a, 2), 8'h55, 1'b1, '0);
      step("R3 mixed priority", 1'b0, ADDR_W'(a), pat(a, 3), 8'h0F, 1'b0, ADDR_W'(a));
      step("R3 newest over older", 1'b1, '0, '0, '0, 1'b0, ADDR_W'(a));
      step("R3 after push", 1'b0, ADDR_W'((a + 5) % DEPTH), pat(a, 4), 8'h81, 1'b0, ADDR_W'(a));
    end
    // R9: idle cycles keep pending entries visible
    step("R9 setup", 1'b0, 4'd3, pat(3, 9), 8'hF0, 1'b1, '0);
    step("R9 setup", 1'b0, 4'd7, pat(7, 9), 8'h3C, 1'b1, '0);
    idle("R9 idle", 25);
    step("R9 pending visible", 1'b1, '0, '0, '0, 1'b0, 4'd3);
    step("R9 pending visible", 1'b1, '0, '0, '0, 1'b0, 4'd7);
    // R4: disabled writes with live-looking inputs have no effect
    for (int a = 0; a < DEPTH; a++) begin
      wrEnN = 1'b1;
      step("R4 disabled write", 1'b1, ADDR_W'(a), ~pat(a, 5), '1, 1'b0, ADDR_W'(a));
    end
    for (int a = 0; a < DEPTH; a++) step("R4 readback", 1'b1, '0, '0, '0, 1'b0, ADDR_W'(a));
    // R1 / R3: pseudo-random traffic against the reference
    for (int i = 0; i < 3000; i++) begin
      seed = nextRand(seed); r1 = seed;
      seed = nextRand(seed); r2 = seed;
      step("R1 random coherence", r1[0] & r1[1], ADDR_W'(r1[7:4] & 4'h7), {r2, r1 ^ 32'hA5A5_5A5A},
           r1[15:8], r1[2] & r1[3], ADDR_W'(r1[19:16] & 4'h7));
    end
    idle("R6 drain", 4);
    for (int a = 0; a < DEPTH; a++) step("R1 final sweep", 1'b1, '0, '0, '0, 1'b0, ADDR_W'(a));
    idle("R6 drain", 4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected<%0d", 150000, 150000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    runMode(1'b0);  // R6 normal latency
    runMode(1'b1);  // R7 legacy latency
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule